// File: doc/BRIEF.md
# Reloading Down-Counting Event Counter

This block is a down counter that advances by one on each qualified event and, when it passes zero, reloads itself from a reload register and keeps running. Events come from one of two places. The first is an asynchronous external line, which is synchronised on chip and qualified on its falling edges, its rising edges or both. The second is the single-cycle underflow pulse of a neighbouring timer. Because every instance exports its own underflow pulse, several instances can be chained into a ring of prescalers.

Software drives the block through a small register port with three locations: a mode byte, the count/reload word and a start flag. A count write goes to both the counter and the reload register while the counter is stopped. While it is running, the write goes to the reload register only, and the counter picks the new value up at its next reload. Each underflow raises a one-cycle interrupt request. With a reload value of n, the block divides its event stream by n+1.

Top module: `evc_counter`

## Requirements
- R1: After a synchronous reset, the mode byte, counter, reload register and start flag are all zero, and `casc_out` and `irq_req` are low.
- R2: Each qualified event decrements the counter by one. An event at count 0 loads the reload value instead, so `casc_out` pulses once every n+1 events for a reload value n.
- R3: With the external source selected, mode bits [3:2] choose the counted edge of `ext_evt`: 00 counts falling edges, 01 counts rising edges and 10 counts both.
- R4: Polarity code 11 on the external source counts no event at all.
- R5: Mode bit 7 selects the source: 0 uses `ext_evt` and 1 uses `casc_in`, counting one event per high cycle. When `casc_in` is the source, `ext_evt` and the polarity bits have no effect.
- R6: Counting happens only while the start flag (address 2, bit 0) is 1. While the flag is 0, the counter holds its value.
- R7: A write to address 1 while stopped loads both the counter and the reload register with the written value.
- R8: A write to address 1 while running changes only the reload register. The counter takes the new value at its next underflow.
- R9: On underflow, `casc_out` and `irq_req` are high together for exactly the one cycle in which the counter first shows the reloaded value.
- R10: The counter counts only when mode bits [1:0] equal 01. Any other value stops all counting.
- R11: `reg_rdata` is registered and reflects `reg_addr` from the previous cycle. Address 0 returns the mode byte, address 1 returns the live count, address 2 returns the start flag, and address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 mode, 1 count/reload, 2 start) |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Registered read data |
| ext_evt | input | 1 | Asynchronous external event line |
| casc_in | input | 1 | Underflow pulse from the neighbouring timer |
| casc_out | output | 1 | Own underflow pulse, for the next timer in the chain |
| irq_req | output | 1 | Interrupt request, one cycle per underflow |

## Verification
The bench builds the block with CNT_W = 8, which makes the whole reload range 0..255 cheap to sweep. For every reload value n, it holds the cascade source high for two full periods and checks that an underflow pulse lands exactly on every (n+1)th cycle. This covers the back-to-back case at n = 0 and the top of the range. The external path is exercised with an asymmetric edge pattern, three falling edges and two rising edges, so that all four polarity codes yield different expected totals. Directed sequences cover the write-while-running reload, the start-flag and operating-mode gating, and the read-back map.

// File: rtl/evc_pkg.sv
package evc_pkg;

  localparam logic [1:0] ADDR_MODE  = 2'd0;
  localparam logic [1:0] ADDR_COUNT = 2'd1;
  localparam logic [1:0] ADDR_START = 2'd2;

  localparam logic [1:0] OP_EVENT = 2'b01;

  typedef enum logic [1:0] {
    POL_FALL = 2'b00,
    POL_RISE = 2'b01,
    POL_BOTH = 2'b10,
    POL_NONE = 2'b11
  } pol_e;

  typedef struct packed {
    logic       src_casc;
    logic [2:0] spare;
    pol_e       pol;
    logic [1:0] op;
  } mode_t;

endpackage

// File: rtl/evc_edge_sync.sv
module evc_edge_sync
  import evc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  pol_e pol,
  output logic edge_ev
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[SYNC_STAGES-1];
  end

  logic rise, fall;
  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall = ~sync_q[SYNC_STAGES-1] & prev_q;

  always_comb begin
    unique case (pol)
      POL_FALL: edge_ev = fall;
      POL_RISE: edge_ev = rise;
      POL_BOTH: edge_ev = rise | fall;
      default:  edge_ev = 1'b0;
    endcase
  end

endmodule

// File: rtl/evc_event_mux.sv
module evc_event_mux
  import evc_pkg::*;
(
  input  mode_t mode,
  input  logic  start,
  input  logic  ext_ev,
  input  logic  casc_ev,
  output logic  count_en
);

  logic src_ev;
  assign src_ev   = mode.src_casc ? casc_ev : ext_ev;
  assign count_en = start && (mode.op == OP_EVENT) && src_ev;

endmodule

// File: rtl/evc_core.sv
module evc_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             running,
  input  logic             count_en,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] rld_q,
  output logic             uflow_q
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] next_rld;
  assign next_rld = load_wr ? load_val : rld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= ZERO;
      rld_q   <= ZERO;
      uflow_q <= 1'b0;
    end else begin
      uflow_q <= 1'b0;
      rld_q   <= next_rld;
      if (load_wr && !running) begin
        cnt_q <= load_val;
      end else if (count_en) begin
        if (cnt_q == ZERO) begin
          cnt_q   <= next_rld;
          uflow_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
    end
  end

endmodule

// File: rtl/evc_regs.sv
module evc_regs
  import evc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  input  logic [CNT_W-1:0] cnt,
  output mode_t            mode_q,
  output logic             start_q,
  output logic             wr_cnt,
  output logic [CNT_W-1:0] rdata_q
);

  assign wr_cnt = reg_wr && (reg_addr == ADDR_COUNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      start_q <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_MODE)  mode_q  <= mode_t'(reg_wdata[7:0]);
      if (reg_addr == ADDR_START) start_q <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      unique case (reg_addr)
        ADDR_MODE:  rdata_q <= CNT_W'(mode_q);
        ADDR_COUNT: rdata_q <= cnt;
        ADDR_START: rdata_q <= CNT_W'(start_q);
        default:    rdata_q <= '0;
      endcase
    end
  end

endmodule

// File: rtl/evc_counter.sv
module evc_counter
  import evc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             ext_evt,
  input  logic             casc_in,
  output logic             casc_out,
  output logic             irq_req
);

  mode_t            mode_q;
  logic             start_q;
  logic             wr_cnt;
  logic             ext_ev;
  logic             count_en;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] rld_q;
  logic             uflow_q;

  evc_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cnt(cnt_q), .mode_q(mode_q),
    .start_q(start_q), .wr_cnt(wr_cnt), .rdata_q(reg_rdata)
  );

  evc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(ext_evt), .pol(mode_q.pol), .edge_ev(ext_ev)
  );

  evc_event_mux u_mux (
    .mode(mode_q), .start(start_q), .ext_ev(ext_ev),
    .casc_ev(casc_in), .count_en(count_en)
  );

  evc_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .running(start_q), .count_en(count_en),
    .load_wr(wr_cnt), .load_val(reg_wdata), .cnt_q(cnt_q),
    .rld_q(rld_q), .uflow_q(uflow_q)
  );

  assign casc_out = uflow_q;
  assign irq_req  = uflow_q;

endmodule

// File: rtl/evc_counter_chk.sv
module evc_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [7:0]       mode,
  input logic             start,
  input logic             wr_cnt,
  input logic [CNT_W-1:0] wdata,
  input logic             count_en,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] rld,
  input logic             uflow,
  input logic             irq
);

  p_dec_r2: assert property (@(posedge clk) disable iff (rst)
    (count_en && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (count_en && cnt == '0) |=> uflow);

  p_pol_none_r4: assert property (@(posedge clk) disable iff (rst)
    (!mode[7] && mode[3:2] == 2'b11) |-> !count_en);

  p_stop_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!start && !wr_cnt) |=> $stable(cnt));

  p_stop_gate_r6: assert property (@(posedge clk) disable iff (rst)
    !start |-> !count_en);

  p_stop_load_r7: assert property (@(posedge clk) disable iff (rst)
    (!start && wr_cnt) |=> (cnt == $past(wdata) && rld == $past(wdata)));

  p_run_write_r8: assert property (@(posedge clk) disable iff (rst)
    (start && wr_cnt && !count_en) |=> ($stable(cnt) && rld == $past(wdata)));

  p_uflow_val_r9: assert property (@(posedge clk) disable iff (rst)
    uflow |-> (cnt == rld));

  p_irq_pair_r9: assert property (@(posedge clk) disable iff (rst)
    irq == uflow);

  p_op_gate_r10: assert property (@(posedge clk) disable iff (rst)
    (mode[1:0] != 2'b01) |-> !count_en);

endmodule

bind evc_counter evc_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode_q), .start(start_q), .wr_cnt(wr_cnt),
  .wdata(reg_wdata), .count_en(count_en), .cnt(cnt_q), .rld(rld_q),
  .uflow(casc_out), .irq(irq_req)
);

// File: tb/evc_counter_bench.sv
module evc_counter_bench;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_wr = 1'b0;
  logic [1:0]   reg_addr = 2'd0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         ext_evt = 1'b0;
  logic         casc_in = 1'b0;
  logic         casc_out, irq_req;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  evc_counter #(.CNT_W(W)) u_evc_counter (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_evt(ext_evt),
    .casc_in(casc_in), .casc_out(casc_out), .irq_req(irq_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = W'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = int'(reg_rdata);
  endtask

  task automatic ext_level(input logic v);
    @(negedge clk);
    ext_evt = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic casc_pulse();
    @(negedge clk);
    casc_in = 1'b1;
    @(negedge clk);
    casc_in = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int v;
    int bad;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 irq/casc low", int'(casc_out) + int'(irq_req), 0);
    rd(2'd0, v); chk("R1 mode", v, 0);
    rd(2'd1, v); chk("R1 count", v, 0);
    rd(2'd2, v); chk("R1 start", v, 0);

    // R11: read map
    wr(2'd0, 8'h8D);
    rd(2'd0, v); chk("R11 mode readback", v, 8'h8D);
    wr(2'd2, 1);
    rd(2'd2, v); chk("R11 start readback", v, 1);
    rd(2'd3, v); chk("R11 unused addr", v, 0);
    wr(2'd2, 0);

    // R3 / R4: polarity sweep, pattern has 3 falling and 2 rising edges
    for (int p = 0; p < 4; p++) begin
      int exp;
      exp = (p == 0) ? 3 : (p == 1) ? 2 : (p == 2) ? 5 : 0;
      wr(2'd2, 0);
      ext_level(1'b1);
      wr(2'd0, 8'h01 | (p << 2));
      wr(2'd1, 100);
      wr(2'd2, 1);
      ext_level(1'b0); ext_level(1'b1); ext_level(1'b0);
      ext_level(1'b1); ext_level(1'b0);
      wr(2'd2, 0);
      rd(2'd1, v);
      if (p == 3) chk("R4 prohibited polarity", v, 100);
      else        chk("R3 edge polarity", v, 100 - exp);
    end

    // R5: cascade source ignores ext and polarity
    wr(2'd0, 8'h8D);
    wr(2'd1, 100);
    wr(2'd2, 1);
    ext_level(1'b1); ext_level(1'b0);
    for (int k = 0; k < 4; k++) casc_pulse();
    wr(2'd2, 0);
    rd(2'd1, v); chk("R5 cascade source", v, 96);

    // R6: stopped counter ignores events; R7 stopped write loads
    wr(2'd0, 8'h81);
    wr(2'd1, 7);
    rd(2'd1, v); chk("R7 stopped write", v, 7);
    for (int k = 0; k < 3; k++) casc_pulse();
    rd(2'd1, v); chk("R6 stopped hold", v, 7);

    // R10: op mode other than 01 blocks counting
    wr(2'd0, 8'h80);
    wr(2'd2, 1);
    for (int k = 0; k < 3; k++) casc_pulse();
    rd(2'd1, v); chk("R10 op mode gate", v, 7);
    wr(2'd2, 0);

    // R8: running write reaches counter only at next reload
    wr(2'd0, 8'h81);
    wr(2'd1, 5);
    wr(2'd2, 1);
    wr(2'd1, 9);
    rd(2'd1, v); chk("R8 running write count untouched", v, 5);
    for (int k = 0; k < 5; k++) casc_pulse();
    rd(2'd1, v); chk("R8 counted down", v, 0);
    casc_pulse();
    rd(2'd1, v); chk("R8 reload picks new value", v, 9);
    wr(2'd2, 0);

    // R2 / R9: exhaustive divide sweep, cascade held high
    bad = 0;
    for (int n = 0; n < 256; n++) begin
      wr(2'd2, 0);
      wr(2'd0, 8'h81);
      wr(2'd1, n);
      wr(2'd2, 1);
      @(negedge clk);
      casc_in = 1'b1;
      for (int i = 1; i <= 2 * (n + 1); i++) begin
        logic e;
        @(negedge clk);
        e = ((i % (n + 1)) == 0);
        if (casc_out != e || irq_req != e) bad++;
        if (i == 2 * (n + 1)) casc_in = 1'b0;
      end
      rd(2'd1, v);
      if (v != n) bad++;
    end
    chk("R2 R9 divide sweep mismatches", bad, 0);
    wr(2'd2, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule